// File: doc/BRIEF.md
# Die Over-Temperature Guard

This block watches the die temperature, given in whole degrees Celsius, and raises three flags for the power-receiver controller. The first flag asks for power transfer to end. The second forces a hard shutdown. The third is a raw over-temperature fault bit. A one-byte configuration register selects the trip point and the hysteresis width. The power-transfer termination request opens a warning band below the trip point, so the transmitter can be told to stop before the hard shutdown is reached.

The temperature bus is sampled only on cycles where the sample strobe is high, and every flag changes only on those cycles. Both flags are latched with hysteresis:
- Shutdown releases once the temperature drops below the trip point.
- The termination request releases only when the temperature is 20 °C under the trip point.

Configuration writes are ordinary byte writes. They take effect from the next sample strobe.

Top module: `dtp_guard`

## Requirements
- R1: After reset the configuration byte holds trip select 1 and hysteresis select 1 (value 0x60), and all three flags are low.
- R2: Configuration bits 7:6 select the trip point: 0 disables the function, 1 selects 130 °C, 2 selects 140 °C and 3 selects 150 °C.
- R3: Configuration bit 5 selects the hysteresis: 0 means 10 °C and 1 means 20 °C. Shutdown sets on a strobe whose sample is at or above the trip point plus the hysteresis.
- R4: Once set, shutdown holds on later strobes while the sample is at or above the trip point. It clears on the first strobe whose sample is below the trip point.
- R5: The termination request sets on a strobe whose sample is at or above the trip point minus 10 °C.
- R6: Once set, the termination request holds while samples stay at or above the trip point minus 20 °C. It clears on the first strobe whose sample is below that level.
- R7: Starting from the idle state, a sample below the trip point minus 10 °C raises no termination request.
- R8: The fault bit equals the comparison "sample at or above the trip point" from the most recent strobe.
- R9: On a strobe with trip select 0, all three flags go low, whatever the temperature.
- R10: On cycles without a strobe, neither the flags nor the internal state change, whatever the temperature input or the configuration does.
- R11: Whenever shutdown is high, the termination request is high as well.
- R12: A write pulse loads the configuration byte on that clock edge. The new settings apply from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_wdata | input | 8 | Configuration byte (bits 7:6 trip select, bit 5 hysteresis select) |
| sample_en | input | 1 | Temperature sample strobe |
| die_temp | input | 8 | Die temperature, unsigned whole °C |
| ept_req | output | 1 | Request to end power transfer |
| shutdown | output | 1 | Hard thermal shutdown |
| ot_fault | output | 1 | Raw over-temperature fault bit |

## Verification
The hardest cases to reach are the two latched hysteresis windows. The first is a sample that lies between the trip point and its shutdown level. The second is a sample that lies between the two termination-request levels. In both windows the expected result depends on the path the temperature took to get there, not only on the current value.

The stimulus walks the temperature up past each level and back down through it, under every trip and hysteresis setting. It also rewrites the configuration and moves the temperature input between strobes, which shows that nothing moves until the next strobe. A long run of random samples and random configuration writes follows. Each clock, a behavioural model compares its result against the outputs.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  typedef enum logic [1:0] {
    ST_COOL = 2'd0,
    ST_WARN = 2'd1,
    ST_SHUT = 2'd2
  } dtp_state_e;

endpackage

// File: rtl/dtp_cfg_reg.sv
module dtp_cfg_reg #(
  parameter int              CFG_W   = 8,
  parameter logic [CFG_W-1:0] RST_VAL = 8'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= RST_VAL;
    else if (wr_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  p_cfg_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cfg_o == $past(wdata_i)));

  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cfg_o));

endmodule

// File: rtl/dtp_limits.sv
module dtp_limits #(
  parameter int LIM_W      = 10,
  parameter int BASE_C     = 130,
  parameter int STEP_C     = 10,
  parameter int HYS_NAR_C  = 10,
  parameter int HYS_WIDE_C = 20,
  parameter int WARN_C     = 10,
  parameter int REL_C      = 20
) (
  input  logic [1:0]       trip_sel_i,
  input  logic             hys_sel_i,
  output logic             active_o,
  output logic [LIM_W-1:0] trip_lim_o,
  output logic [LIM_W-1:0] shut_lim_o,
  output logic [LIM_W-1:0] warn_lim_o,
  output logic [LIM_W-1:0] rel_lim_o
);

  localparam logic [LIM_W-1:0] BASE_V = LIM_W'(BASE_C);
  localparam logic [LIM_W-1:0] STEP_V = LIM_W'(STEP_C);
  localparam logic [LIM_W-1:0] HYS_N  = LIM_W'(HYS_NAR_C);
  localparam logic [LIM_W-1:0] HYS_W  = LIM_W'(HYS_WIDE_C);
  localparam logic [LIM_W-1:0] WARN_V = LIM_W'(WARN_C);
  localparam logic [LIM_W-1:0] REL_V  = LIM_W'(REL_C);

  logic [LIM_W-1:0] steps;

  always_comb begin
    active_o   = (trip_sel_i != 2'd0);
    steps      = active_o ? LIM_W'(trip_sel_i - 2'd1) : '0;
    trip_lim_o = BASE_V + steps * STEP_V;
    shut_lim_o = trip_lim_o + (hys_sel_i ? HYS_W : HYS_N);
    warn_lim_o = trip_lim_o - WARN_V;
    rel_lim_o  = trip_lim_o - REL_V;
  end

endmodule

// File: rtl/dtp_trip_fsm.sv
module dtp_trip_fsm
  import dtp_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int LIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              active_i,
  input  logic [LIM_W-1:0]  trip_lim_i,
  input  logic [LIM_W-1:0]  shut_lim_i,
  input  logic [LIM_W-1:0]  warn_lim_i,
  input  logic [LIM_W-1:0]  rel_lim_i,
  output logic              ept_o,
  output logic              sd_o,
  output logic              fault_o
);

  dtp_state_e       state_q, state_d;
  logic             fault_q, fault_d;
  logic [LIM_W-1:0] t_ext;

  assign t_ext = LIM_W'(temp_i);

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    if (strobe_i) begin
      if (!active_i) begin
        state_d = ST_COOL;
        fault_d = 1'b0;
      end else begin
        fault_d = (t_ext >= trip_lim_i);
        unique case (state_q)
          ST_COOL: begin
            if (t_ext >= shut_lim_i)      state_d = ST_SHUT;
            else if (t_ext >= warn_lim_i) state_d = ST_WARN;
          end
          ST_WARN: begin
            if (t_ext >= shut_lim_i)      state_d = ST_SHUT;
            else if (t_ext < rel_lim_i)   state_d = ST_COOL;
          end
          ST_SHUT: begin
            if (t_ext < rel_lim_i)        state_d = ST_COOL;
            else if (t_ext < trip_lim_i)  state_d = ST_WARN;
          end
          default:                        state_d = ST_COOL;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COOL;
      fault_q <= 1'b0;
    end else if (strobe_i) begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign ept_o   = (state_q != ST_COOL);
  assign sd_o    = (state_q == ST_SHUT);
  assign fault_o = fault_q;

  p_quiet_between_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(state_q) && $stable(fault_q)));

  p_shutdown_implies_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sd_o |-> ept_o);

  p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !active_i) |=> (!ept_o && !sd_o && !fault_o));

  p_trip_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && active_i && (t_ext >= shut_lim_i)) |=> sd_o);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && active_i && (t_ext < rel_lim_i)) |=> !ept_o);

  p_warn_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && active_i && (t_ext >= warn_lim_i)) |=> ept_o);

endmodule

// File: rtl/dtp_guard.sv
module dtp_guard #(
  parameter int          TEMP_W     = 8,
  parameter int          CFG_W      = 8,
  parameter int          BASE_C     = 130,
  parameter int          STEP_C     = 10,
  parameter int          HYS_NAR_C  = 10,
  parameter int          HYS_WIDE_C = 20,
  parameter int          WARN_C     = 10,
  parameter int          REL_C      = 20,
  parameter logic [7:0]  CFG_RST    = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              sample_en,
  input  logic [TEMP_W-1:0] die_temp,
  output logic              ept_req,
  output logic              shutdown,
  output logic              ot_fault
);

  localparam int LIM_W   = TEMP_W + 2;
  localparam int SEL_HI  = CFG_W - 1;
  localparam int SEL_LO  = CFG_W - 2;
  localparam int HYS_BIT = CFG_W - 3;

  logic [CFG_W-1:0] cfg;
  logic             active;
  logic [LIM_W-1:0] trip_lim, shut_lim, warn_lim, rel_lim;

  dtp_cfg_reg #(
    .CFG_W   (CFG_W),
    .RST_VAL (CFG_W'(CFG_RST))
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cfg_wr),
    .wdata_i (cfg_wdata),
    .cfg_o   (cfg)
  );

  dtp_limits #(
    .LIM_W      (LIM_W),
    .BASE_C     (BASE_C),
    .STEP_C     (STEP_C),
    .HYS_NAR_C  (HYS_NAR_C),
    .HYS_WIDE_C (HYS_WIDE_C),
    .WARN_C     (WARN_C),
    .REL_C      (REL_C)
  ) u_lim (
    .trip_sel_i (cfg[SEL_HI:SEL_LO]),
    .hys_sel_i  (cfg[HYS_BIT]),
    .active_o   (active),
    .trip_lim_o (trip_lim),
    .shut_lim_o (shut_lim),
    .warn_lim_o (warn_lim),
    .rel_lim_o  (rel_lim)
  );

  dtp_trip_fsm #(
    .TEMP_W (TEMP_W),
    .LIM_W  (LIM_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (sample_en),
    .temp_i     (die_temp),
    .active_i   (active),
    .trip_lim_i (trip_lim),
    .shut_lim_i (shut_lim),
    .warn_lim_i (warn_lim),
    .rel_lim_i  (rel_lim),
    .ept_o      (ept_req),
    .sd_o       (shutdown),
    .fault_o    (ot_fault)
  );

endmodule

// File: tb/dtp_guard_test.sv
`timescale 1ns/1ps
module dtp_guard_test;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic       sample_en;
  logic [7:0] die_temp;
  logic       ept_req, shutdown, ot_fault;

  int    checks   = 0;
  int    failures = 0;
  int    cycles   = 0;
  bit    running  = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  int m_cfg, m_state, m_fault;

  dtp_guard uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .sample_en (sample_en),
    .die_temp  (die_temp),
    .ept_req   (ept_req),
    .shutdown  (shutdown),
    .ot_fault  (ot_fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: state 0 idle, 1 request only, 2 shutdown
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg   = 'h60;
      m_state = 0;
      m_fault = 0;
    end else begin
      if (sample_en) begin
        int sel, th, hy, t;
        sel = (m_cfg >> 6) & 3;
        if (sel == 0) begin
          m_state = 0;
          m_fault = 0;
        end else begin
          th = 130 + 10 * (sel - 1);
          hy = ((m_cfg >> 5) & 1) ? 20 : 10;
          t  = die_temp;
          m_fault = (t >= th);
          if (t >= th + hy)                       m_state = 2;
          else if (m_state == 0 && t >= th - 10)  m_state = 1;
          else if (m_state != 0 && t < th - 20)   m_state = 0;
          else if (m_state == 2 && t < th)        m_state = 1;
        end
      end
      if (cfg_wr) m_cfg = cfg_wdata;
    end
  end

  task automatic check3(string req);
    int e_ept, e_sd;
    e_ept = (m_state != 0);
    e_sd  = (m_state == 2);
    checks++;
    if (ept_req !== e_ept[0] || shutdown !== e_sd[0] || ot_fault !== m_fault[0]) begin
      failures++;
      $display("FAIL %s: ept/sd/fault actual=%b%b%b expected=%0d%0d%0d at t=%0t",
               req, ept_req, shutdown, ot_fault, e_ept, e_sd, m_fault, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) check3(cur_req);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_en = 1'b0;
      cfg_wr    = 1'b0;
    end
  endtask

  task automatic sample(int t);
    @(negedge clk);
    cfg_wr    = 1'b0;
    die_temp  = 8'(t);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic write_cfg(int v);
    @(negedge clk);
    sample_en = 1'b0;
    cfg_wdata = 8'(v);
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic expect_flags(string req, bit e, bit s, bit f);
    checks++;
    if (ept_req !== e || shutdown !== s || ot_fault !== f) begin
      failures++;
      $display("FAIL %s: ept/sd/fault actual=%b%b%b expected=%b%b%b",
               req, ept_req, shutdown, ot_fault, e, s, f);
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; sample_en = 1'b0; die_temp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_flags("R1 reset", 1'b0, 1'b0, 1'b0);
    running = 1;

    // default 130 / 20: shutdown 150, request 120, release 110
    cur_req = "R7"; sample(115); sample(119);
    expect_flags("R7 below band", 1'b0, 1'b0, 1'b0);
    cur_req = "R5"; sample(120);
    expect_flags("R5 request set", 1'b1, 1'b0, 1'b0);
    cur_req = "R6"; sample(110); sample(112);
    expect_flags("R6 request held", 1'b1, 1'b0, 1'b0);
    sample(109);
    expect_flags("R6 request release", 1'b0, 1'b0, 1'b0);
    cur_req = "R8"; sample(130);
    expect_flags("R8 fault at trip", 1'b1, 1'b0, 1'b1);
    sample(129);
    expect_flags("R8 fault clears", 1'b1, 1'b0, 1'b0);
    cur_req = "R3"; sample(149);
    expect_flags("R3 below shutdown", 1'b1, 1'b0, 1'b1);
    sample(150);
    expect_flags("R3 shutdown at 150", 1'b1, 1'b1, 1'b1);
    cur_req = "R4"; sample(131); sample(130);
    expect_flags("R4 shutdown held", 1'b1, 1'b1, 1'b1);
    sample(129);
    expect_flags("R4 shutdown release", 1'b1, 1'b0, 1'b0);

    // R10: no strobe, temperature and config move, nothing changes
    cur_req = "R10";
    @(negedge clk); die_temp = 8'd250;
    idle(5);
    write_cfg('h00);
    idle(3);
    expect_flags("R10 no strobe no change", 1'b1, 1'b0, 1'b0);
    cur_req = "R9"; sample(250);
    expect_flags("R9 off clears", 1'b0, 1'b0, 1'b0);
    sample(200);

    // R2/R12: other trip points and hysteresis widths
    cur_req = "R2"; write_cfg('hC0); sample(100);
    sample(159);
    expect_flags("R2 150 trip no shutdown at 159", 1'b1, 1'b0, 1'b1);
    sample(160);
    expect_flags("R2 R3 shutdown at 160", 1'b1, 1'b1, 1'b1);
    sample(100);
    cur_req = "R12"; write_cfg('h40); sample(139);
    expect_flags("R12 130/10 below 140", 1'b1, 1'b0, 1'b1);
    sample(140);
    expect_flags("R12 130/10 shutdown", 1'b1, 1'b1, 1'b1);
    sample(0);
    cur_req = "R2"; write_cfg('hA0); sample(129);
    expect_flags("R2 140 trip request at 130 band", 1'b0, 1'b0, 1'b0);
    sample(130); sample(159); sample(160);
    expect_flags("R2 140/20 shutdown", 1'b1, 1'b1, 1'b1);
    sample(0);

    // random sweep, model compared every clock
    cur_req = "R11 random";
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 17) == 0) write_cfg($urandom % 256);
      sample(95 + ($urandom % 85));
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end

    running = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule